// File: doc/BRIEF.md
# Shared Reload Baud-Rate Generator

This block is a baud-rate source shared by several UARTs. An up-counter is loaded from a programmable reload value and counts to its all-ones state. Each wrap produces an overflow pulse. The counter advances on a clock enable from a small prescaler. By default the prescaler divides by six and by two. A fast-speed bit removes the divide-by-six stage. A clock-double input, driven by the chip's clock-mode logic, removes the divide-by-two stage.

Each UART port has its own configuration. One bit routes the generator to the port's transmit 16x sample tick, and another routes it to the port's receive 16x sample tick. A per-port double bit decides whether the port uses every overflow or every second one. A path that does not pick the generator passes the port's timer overflow input through instead.

The resulting 16x tick rate is Fosc × 2^dbl × 2^clkdbl / (4 × 6^(1−fast) × (256 − reload)). Software writes the configuration through a simple write-only register port.

Top module: `baud_share_gen`

## Requirements
- R1: The reload register resets to 00h. With fast=1, clock-double=1 and port double=1, an unwritten reload value gives a selected tick every 256 clock cycles.
- R2: The counter advances once per prescaler enable and reloads on every wrap from all-ones. With fast=1, clock-double=1 and double=1, the tick period is (256 − reload) cycles. Reload 0xF0 gives 16 cycles, and reload 0xFF gives a tick every cycle.
- R3: Control bit 1 (fast) set to 0 inserts a divide-by-6 before the counter, so the period is multiplied by 6.
- R4: Input `clk_dbl_i` low inserts a divide-by-2 before the counter, so the period is multiplied by 2.
- R5: Port config bit 2 (double) set to 1 emits a tick on every overflow. Set to 0, it emits a tick on every second overflow, counted from the start of the run.
- R6: Port config bit 0 selects the generator for that port's transmit tick, and bit 1 selects it for that port's receive tick. The two bits are independent of each other and of other ports.
- R7: A transmit or receive path that is not selected outputs the port's `tmr_ovf_i` bit, delayed by one clock.
- R8: While control bit 0 (run) is 0, the counter and prescaler hold, and no generator tick reaches any port.
- R9: When run changes from 0 to 1, the counter loads the reload value. With fast=1, clock-double=1 and double=1, the first tick appears 3 + (256 − reload) cycles after the cycle in which the control write is presented.
- R10: After reset all outputs are low, run is 0, and every port selects its timer input.
- R11: Write addresses are decoded as follows: address 0 is the reload register, address 1 is control (bit 0 run, bit 1 fast), and address 2+u is the config of port u.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| clk_dbl_i | input | 1 | Clock-double mode from clock control (1 = no divide-by-2) |
| tmr_ovf_i | input | NUM_PORTS | Per-port timer overflow fallback ticks |
| tx_tick_o | output | NUM_PORTS | Per-port transmit 16x sample tick |
| rx_tick_o | output | NUM_PORTS | Per-port receive 16x sample tick |

## Verification
The bench builds the block with NUM_PORTS=3 and the other parameters at their defaults. Three ports make the per-port generate loop repeat beyond the two-port default and widen the write address to three bits. This lets one port run double, another run halved, and a third select only its receive path, all at the same time. The default reload width keeps every reload value from 00h to FFh reachable, including the one-cycle period at FFh and the longest 3072-cycle period.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
   localparam int REG_RELOAD = 0;
   localparam int REG_CTRL   = 1;
   localparam int REG_PORT0  = 2;

   localparam int CTL_RUN  = 0;
   localparam int CTL_FAST = 1;

   localparam int PC_TX  = 0;
   localparam int PC_RX  = 1;
   localparam int PC_DBL = 2;

   typedef struct packed {
      logic dbl;
      logic rx_sel;
      logic tx_sel;
   } port_cfg_t;
endpackage

// File: rtl/bsg_prescaler.sv
module bsg_prescaler #(
   parameter int SLOW_DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic start_i,
   input  logic fast_i,
   input  logic clk_dbl_i,
   output logic ce_o
);
   localparam int MAX_PER = 2 * SLOW_DIV;
   localparam int PW      = $clog2(MAX_PER + 1);

   logic [PW-1:0] period;
   logic [PW-1:0] pre_q;
   logic          hit;

   always_comb begin
      period = fast_i ? PW'(1) : PW'(SLOW_DIV);
      if (!clk_dbl_i) period = period << 1;
   end

   assign hit  = (pre_q >= period - PW'(1));
   assign ce_o = run_i && !start_i && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pre_q <= '0;
      else if (!run_i || start_i) pre_q <= '0;
      else if (hit)               pre_q <= '0;
      else                        pre_q <= pre_q + PW'(1);
   end

   assert_prescale_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i) |=> (pre_q == '0));
endmodule

// File: rtl/bsg_reload_counter.sv
module bsg_reload_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             start_i,
   input  logic             ce_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             ovf_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = ce_i && (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_o <= 1'b0;
      end else begin
         ovf_o <= wrap && !start_i;
         if (start_i)   cnt_q <= reload_i;
         else if (wrap) cnt_q <= reload_i;
         else if (ce_i) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assert_start_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == $past(reload_i)));
   assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && !start_i && cnt_q == '1) |=> (cnt_q == $past(reload_i)));
   assert_hold_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bsg_port_route.sv
module bsg_port_route
   import bsg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run_i,
   input  logic      gen_ovf_i,
   input  port_cfg_t cfg_i,
   input  logic      tmr_ovf_i,
   output logic      tx_tick_o,
   output logic      rx_tick_o
);
   logic half_q;
   logic port_tick;

   assign port_tick = gen_ovf_i && (cfg_i.dbl || half_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q    <= 1'b0;
         tx_tick_o <= 1'b0;
         rx_tick_o <= 1'b0;
      end else begin
         if (!run_i)         half_q <= 1'b0;
         else if (gen_ovf_i) half_q <= !half_q;
         tx_tick_o <= cfg_i.tx_sel ? port_tick : tmr_ovf_i;
         rx_tick_o <= cfg_i.rx_sel ? port_tick : tmr_ovf_i;
      end
   end

   assert_fallback_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.tx_sel) |=> (tx_tick_o == $past(tmr_ovf_i)));
   assert_fallback_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.rx_sel) |=> (rx_tick_o == $past(tmr_ovf_i)));
endmodule

// File: rtl/baud_share_gen.sv
module baud_share_gen
   import bsg_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int CNT_W     = 8,
   parameter int DATA_W    = 8,
   parameter int SLOW_DIV  = 6,
   localparam int ADDR_W   = $clog2(NUM_PORTS + REG_PORT0)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [ADDR_W-1:0]    wr_addr_i,
   input  logic [DATA_W-1:0]    wr_data_i,
   input  logic                 clk_dbl_i,
   input  logic [NUM_PORTS-1:0] tmr_ovf_i,
   output logic [NUM_PORTS-1:0] tx_tick_o,
   output logic [NUM_PORTS-1:0] rx_tick_o
);
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (CNT_W > DATA_W) begin : g_bad_width
      $error("CNT_W must not exceed DATA_W");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("DATA_W must hold the port config bits");
   end
   if (SLOW_DIV < 2) begin : g_bad_div
      $error("SLOW_DIV must be at least 2");
   end

   logic [CNT_W-1:0] reload_q;
   logic             run_q, fast_q, run_d;
   logic             start, ce, gen_ovf;
   port_cfg_t        cfg_q [NUM_PORTS];

   assign start = run_q && !run_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         run_q    <= 1'b0;
         fast_q   <= 1'b0;
         run_d    <= 1'b0;
      end else begin
         run_d <= run_q;
         if (wr_en_i && wr_addr_i == ADDR_W'(REG_RELOAD))
            reload_q <= wr_data_i[CNT_W-1:0];
         if (wr_en_i && wr_addr_i == ADDR_W'(REG_CTRL)) begin
            run_q  <= wr_data_i[CTL_RUN];
            fast_q <= wr_data_i[CTL_FAST];
         end
      end
   end

   bsg_prescaler #(.SLOW_DIV(SLOW_DIV)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .start_i   (start),
      .fast_i    (fast_q),
      .clk_dbl_i (clk_dbl_i),
      .ce_o      (ce)
   );

   bsg_reload_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_q),
      .start_i  (start),
      .ce_i     (ce),
      .reload_i (reload_q),
      .ovf_o    (gen_ovf)
   );

   for (genvar u = 0; u < NUM_PORTS; u++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[u] <= '0;
         end else if (wr_en_i && wr_addr_i == ADDR_W'(REG_PORT0 + u)) begin
            cfg_q[u].tx_sel <= wr_data_i[PC_TX];
            cfg_q[u].rx_sel <= wr_data_i[PC_RX];
            cfg_q[u].dbl    <= wr_data_i[PC_DBL];
         end
      end

      bsg_port_route u_route (
         .clk       (clk),
         .rst_n     (rst_n),
         .run_i     (run_q),
         .gen_ovf_i (gen_ovf),
         .cfg_i     (cfg_q[u]),
         .tmr_ovf_i (tmr_ovf_i[u]),
         .tx_tick_o (tx_tick_o[u]),
         .rx_tick_o (rx_tick_o[u])
      );
   end

   assert_no_ovf_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q) |=> !gen_ovf);
endmodule

// File: tb/baud_share_gen_tb.sv
module baud_share_gen_tb;
   localparam int NP = 3;
   localparam int AW = $clog2(NP + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          clk_dbl = 1'b1;
   logic [NP-1:0] tmr_ovf = '0;
   logic [NP-1:0] tx_tick, rx_tick;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   baud_share_gen #(.NUM_PORTS(NP)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .clk_dbl_i (clk_dbl),
      .tmr_ovf_i (tmr_ovf),
      .tx_tick_o (tx_tick),
      .rx_tick_o (rx_tick)
   );

   // scoreboard: expected periods, popped by the monitor
   int    exp_q[$];
   string cur_tag = "";
   int    mon_sel = 0;
   bit    mon_restart = 1'b0;
   bit    have_prev = 1'b0;
   int    cyc = 0;

   function automatic logic stream_bit(input int s);
      return (s % 2 == 0) ? tx_tick[s/2] : rx_tick[s/2];
   endfunction

   always @(negedge clk) begin
      if (mon_restart) begin
         have_prev   = 1'b0;
         cyc         = 0;
         mon_restart = 1'b0;
      end else begin
         cyc++;
         if (stream_bit(mon_sel)) begin
            if (have_prev && exp_q.size() > 0) begin
               int e;
               e = exp_q.pop_front();
               checks++;
               if (cyc != e) begin
                  failures++;
                  $display("FAIL %s: tick period actual=%0d expected=%0d", cur_tag, cyc, e);
               end
            end
            have_prev = 1'b1;
            cyc = 0;
         end
      end
   end

   function automatic int period(input int brl, input bit fast, input bit x2, input bit dbl);
      return (256 - brl) * (fast ? 1 : 6) * (x2 ? 1 : 2) * (dbl ? 1 : 2);
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(input int s, input int e, input string tag);
      @(negedge clk);
      cur_tag = tag;
      mon_sel = s;
      mon_restart = 1'b1;
      for (int i = 0; i < 3; i++) exp_q.push_back(e);
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(|tx_tick, 1'b0, "R10 tx idle after reset");
      chk(|rx_tick, 1'b0, "R10 rx idle after reset");
      // R7/R10: fallback path after reset
      tmr_ovf = 3'b001;
      @(negedge clk);
      tmr_ovf = '0;
      chk(tx_tick[0], 1'b1, "R7 tx fallback follows timer");
      chk(rx_tick[0], 1'b1, "R7 rx fallback follows timer");
      chk(tx_tick[1], 1'b0, "R7 other port untouched");
      @(negedge clk);
      chk(tx_tick[0], 1'b0, "R7 fallback pulse one cycle");

      // R1: reload untouched -> 256
      wr(2, 3'b101);
      wr(1, 2'b11);
      measure(0, period(0, 1, 1, 1), "R1 reset reload period");

      // R8: stop
      wr(1, 2'b10);
      cnt = 0;
      repeat (600) begin
         @(negedge clk);
         if (tx_tick[0]) cnt++;
      end
      checks++;
      if (cnt != 0) begin
         failures++;
         $display("FAIL R8 ticks while stopped: actual=%0d expected=0", cnt);
      end

      // R2, R11
      wr(0, 8'hF0);
      wr(1, 2'b11);
      measure(0, period(8'hF0, 1, 1, 1), "R2 reload F0 period");

      // R5/R6: port1 both paths, halved; port2 rx only, double
      wr(3, 3'b011);
      wr(4, 3'b110);
      measure(2, period(8'hF0, 1, 1, 0), "R5 port1 tx halved");
      measure(3, period(8'hF0, 1, 1, 0), "R6 port1 rx selected");
      measure(5, period(8'hF0, 1, 1, 1), "R6 port2 rx only");
      cnt = 0;
      repeat (100) begin
         @(negedge clk);
         if (rx_tick[0] || tx_tick[2]) cnt++;
      end
      checks++;
      if (cnt != 0) begin
         failures++;
         $display("FAIL R6 unselected paths ticked: actual=%0d expected=0", cnt);
      end
      tmr_ovf = 3'b100;
      @(negedge clk);
      tmr_ovf = '0;
      chk(tx_tick[2], 1'b1, "R7 port2 tx fallback while running");

      // R3: slow prescaler
      wr(1, 2'b01);
      measure(0, period(8'hF0, 0, 1, 1), "R3 divide by 6");
      // R4: clock double off
      @(negedge clk);
      clk_dbl = 1'b0;
      measure(0, period(8'hF0, 0, 0, 1), "R4 divide by 2");
      @(negedge clk);
      clk_dbl = 1'b1;
      wr(1, 2'b11);

      // R2 boundary: FF
      wr(0, 8'hFF);
      measure(0, 1, "R2 reload FF every cycle");

      // R9: start loads reload
      wr(1, 2'b10);
      wr(0, 8'hFE);
      wr(1, 2'b11);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(tx_tick[0], 1'b0, "R9 no tick before first wrap");
      end
      @(negedge clk);
      chk(tx_tick[0], 1'b1, "R9 first tick after start load");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule